// File: doc/BRIEF.md
# Page Fault Status and Interrupt Register

This block holds the processor's page-fault status word. When address translation reports a fault, it records which kind of fault occurred. It also keeps a pending-fault flag that, together with a single-step completion flag, drives one interrupt request line. A translation reference can carry an inhibit flag. The fault kind is still recorded for such a reference, but the pending-fault flag is not raised, so the monitor can tidy up first. A later software force-fault command reloads a saved word and sets the pending flag without touching the recorded kind, and the deferred interrupt is then taken.

Software saves the whole word with a store command and can reload it with a load command. Other hardware events can arrive in the same cycle as a software load. These are applied on top of the value being loaded, so none of them is lost.

Status word layout:
- bit 0: step-done
- bit 1: fault-pending
- bit 2: table-NXM
- bit 3: no-access
- bit 4: write into read-only
- bit 5: write into read-write-first
- bit 6: exec-mapping, constant 1
- bits 11:7: read as 0

Top module: `fault_status_reg`

## Requirements
- R1: A fault event with reason code 0 (no access), 1 (write into read-only), 2 (write into read-write-first) or 3 (NXM during table fetch) leaves exactly one of the reason bits set in the next cycle: bit 3, 4, 5 or 2 respectively. The other three reason bits are cleared.
- R2: A fault event with the inhibit flag low sets bit 1 (fault-pending) in the next cycle.
- R3: A fault event with the inhibit flag high records its reason bits as in R1 but leaves bit 1 unchanged.
- R4: The force command loads the supplied word and sets bit 1 in the same update, keeping the supplied reason bits as given.
- R5: An instruction-complete event sets bit 0 only when the single-step flag is high. When the flag is low, the event has no effect.
- R6: An NXM event from a state load/store or table fetch sets bit 2 and leaves every other bit as it was.
- R7: The load command replaces the register with the supplied word. Bits 11:7 read 0 afterwards. A load with bits 0 and 1 clear drops the interrupt request in the next cycle. Hardware events in the same cycle are applied after the loaded value.
- R8: A fault arriving while bit 1 is already set overwrites the reason bits with the newest reason.
- R9: Bit 6 (exec-mapping) reads 1 at all times after reset, whatever software loads.
- R10: The interrupt request equals bit 0 OR bit 1 of the register. It stays high until software clears both bits.
- R11: The store command copies the register value as it stood before that cycle's update into the saved-word output, one cycle later.
- R12: After reset the register reads 0x040, the saved word reads 0 and the interrupt request is low.

Top module port list order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_valid | input | 1 | Page fault reported by translation |
| flt_code | input | 2 | Fault reason code |
| flt_inhibit | input | 1 | Inhibit flag of the relocated-execute reference |
| step_done | input | 1 | Instruction completed |
| step_flag | input | 1 | Single-step flag of the running PC |
| nxm_evt | input | 1 | Nonexistent memory during table fetch or state transfer |
| sw_load | input | 1 | Software load of the status word |
| sw_force | input | 1 | Software load plus set of fault-pending |
| sw_store | input | 1 | Software save of the status word |
| sw_data | input | 12 | Word supplied by load or force |
| stat_o | output | 12 | Current status word |
| store_o | output | 12 | Last saved status word |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions take for granted that sw_load and sw_force are never high together, and that flt_code is only sampled while flt_valid is high. The inhibit-hold property further assumes that no load or force sets bit 1 in the same cycle. Every stimulus vector and directed test keeps the two software commands exclusive. The one vector that combines a load with an inhibited fault loads a word whose bit 1 is already set, so the inhibit property is excluded by its own guard.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int STAT_W = 12;
  localparam int CODE_W = 2;

  localparam int B_STEP  = 0;
  localparam int B_FLT   = 1;
  localparam int B_NXM   = 2;
  localparam int B_DENY  = 3;
  localparam int B_WRO   = 4;
  localparam int B_WRF   = 5;
  localparam int B_EXMAP = 6;
  localparam int USED_W  = B_EXMAP + 1;

  typedef enum logic [CODE_W-1:0] {
    RSN_DENY = 2'd0,
    RSN_WRO  = 2'd1,
    RSN_WRF  = 2'd2,
    RSN_NXM  = 2'd3
  } rsn_e;

  // one-hot reason bit for a code
  function automatic logic [STAT_W-1:0] rsn_bit(input logic [CODE_W-1:0] code);
    logic [STAT_W-1:0] m;
    m = '0;
    case (rsn_e'(code))
      RSN_DENY: m[B_DENY] = 1'b1;
      RSN_WRO:  m[B_WRO]  = 1'b1;
      RSN_WRF:  m[B_WRF]  = 1'b1;
      default:  m[B_NXM]  = 1'b1;
    endcase
    return m;
  endfunction

  function automatic logic [STAT_W-1:0] rsn_all();
    logic [STAT_W-1:0] m;
    m = '0;
    m[B_DENY] = 1'b1;
    m[B_WRO]  = 1'b1;
    m[B_WRF]  = 1'b1;
    m[B_NXM]  = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/fsr_base_sel.sv
module fsr_base_sel
  import fsr_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] sw_data_i,
  input  logic         sw_load_i,
  input  logic         sw_force_i,
  output logic [W-1:0] base_o
);
  always_comb begin
    if (sw_load_i || sw_force_i) base_o = sw_data_i;
    else                         base_o = cur_i;
    if (sw_force_i) base_o[B_FLT] = 1'b1;
  end
endmodule

// File: rtl/fsr_event_merge.sv
module fsr_event_merge
  import fsr_pkg::*;
#(
  parameter int W  = STAT_W,
  parameter int CW = CODE_W
) (
  input  logic [W-1:0]  base_i,
  input  logic          flt_valid_i,
  input  logic [CW-1:0] flt_code_i,
  input  logic          flt_inhibit_i,
  input  logic          step_hit_i,
  input  logic          nxm_evt_i,
  output logic [W-1:0]  nxt_o
);
  localparam logic [W-1:0] RSN_MASK = W'(rsn_all());

  logic [W-1:0] keep_mask;
  logic [W-1:0] const_one;

  // bits above the defined layout are forced to zero
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_mask
      if (g < USED_W) begin : g_used
        assign keep_mask[g] = 1'b1;
      end else begin : g_rsvd
        assign keep_mask[g] = 1'b0;
      end
      if (g == B_EXMAP) begin : g_one
        assign const_one[g] = 1'b1;
      end else begin : g_zero
        assign const_one[g] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    nxt_o = base_i;
    if (flt_valid_i) begin
      nxt_o = (nxt_o & ~RSN_MASK) | W'(rsn_bit(flt_code_i));
      if (!flt_inhibit_i) nxt_o[B_FLT] = 1'b1;
    end
    if (nxm_evt_i)  nxt_o[B_NXM]  = 1'b1;
    if (step_hit_i) nxt_o[B_STEP] = 1'b1;
    nxt_o = (nxt_o & keep_mask) | const_one;
  end
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg
  import fsr_pkg::*;
#(
  parameter int W  = STAT_W,
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flt_valid,
  input  logic [CW-1:0] flt_code,
  input  logic          flt_inhibit,
  input  logic          step_done,
  input  logic          step_flag,
  input  logic          nxm_evt,
  input  logic          sw_load,
  input  logic          sw_force,
  input  logic          sw_store,
  input  logic [W-1:0]  sw_data,
  output logic [W-1:0]  stat_o,
  output logic [W-1:0]  store_o,
  output logic          irq_o
);
  localparam logic [W-1:0] RESET_VAL = W'(1) << B_EXMAP;
  localparam logic [W-1:0] RSN_MASK  = W'(rsn_all());

  logic [W-1:0] stat_q, stat_d;
  logic [W-1:0] store_q, store_d;
  logic [W-1:0] base;
  logic         step_hit;
  logic         stat_en;

  assign step_hit = step_done & step_flag;
  assign stat_en  = sw_load | sw_force | flt_valid | nxm_evt | step_hit;

  fsr_base_sel #(.W(W)) u_base (
    .cur_i      (stat_q),
    .sw_data_i  (sw_data),
    .sw_load_i  (sw_load),
    .sw_force_i (sw_force),
    .base_o     (base)
  );

  fsr_event_merge #(.W(W), .CW(CW)) u_merge (
    .base_i        (base),
    .flt_valid_i   (flt_valid),
    .flt_code_i    (flt_code),
    .flt_inhibit_i (flt_inhibit),
    .step_hit_i    (step_hit),
    .nxm_evt_i     (nxm_evt),
    .nxt_o         (stat_d)
  );

  always_comb begin
    store_d = store_q;
    if (sw_store) store_d = stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= RESET_VAL;
      store_q <= '0;
    end else begin
      if (stat_en)  stat_q  <= stat_d;
      if (sw_store) store_q <= store_d;
    end
  end

  assign stat_o  = stat_q;
  assign store_o = store_q;
  assign irq_o   = stat_q[B_STEP] | stat_q[B_FLT];

  // R1 / R3: reason field matches the latest fault code
  a_r1_reason_latch: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |=> ((stat_q & RSN_MASK) == W'(rsn_bit($past(flt_code)))));

  // R2: uninhibited fault raises the pending bit
  a_r2_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !flt_inhibit) |=> stat_q[B_FLT]);

  // R3: inhibited fault holds the pending bit
  a_r3_inhibit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && flt_inhibit && !sw_force && !sw_load) |=> $stable(stat_q[B_FLT]));

  // R5: step event without the flag changes nothing on bit 0
  a_r5_step_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (step_done && !step_flag && !sw_load && !sw_force) |=> $stable(stat_q[B_STEP]));

  // R9: exec-mapping bit constant
  a_r9_exmap_one: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[B_EXMAP]);

  // R10: request only falls after a software load
  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(sw_load));

  // R11: saved word follows the register
  a_r11_store: assert property (@(posedge clk) disable iff (!rst_n)
    sw_store |=> (store_q == $past(stat_q)));
endmodule

// File: tb/fault_status_reg_test.sv
module fault_status_reg_test;
  localparam int PERIOD = 10;
  localparam int W = 12;

  typedef struct packed {
    logic        fv;
    logic [1:0]  code;
    logic        inh;
    logic        sd;
    logic        sf;
    logic        nx;
    logic        ld;
    logic        fc;
    logic [W-1:0] data;
    logic [W-1:0] exp;
    logic        irq;
  } vec_t;

  localparam int NV = 15;
  // fv code inh sd sf nx ld fc data exp irq
  localparam vec_t TBL [NV] = '{
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 12'h040, 1'b0}, // R12 idle
    '{1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 12'h04A, 1'b1}, // R1 R2
    '{1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 12'h052, 1'b1}, // R8
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'h000, 12'h040, 1'b0}, // R7 R10
    '{1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 12'h060, 1'b0}, // R3
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 12'h060, 12'h062, 1'b1}, // R4
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'hFFD, 12'h07D, 1'b1}, // R7 R9 R10
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'h000, 12'h040, 1'b0}, // R7 R9
    '{1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 12'h040, 1'b0}, // R5 no flag
    '{1'b0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 12'h041, 1'b1}, // R5
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 12'h000, 12'h044, 1'b0}, // R6 R7
    '{1'b1, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 12'h044, 1'b0}, // R1 code 3
    '{1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 12'h048, 1'b0}, // R1 clears NXM
    '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 12'h000, 12'h04C, 1'b0}, // R6 keeps rest
    '{1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 12'h002, 12'h052, 1'b1}  // R7 same cycle
  };

  logic clk = 1'b0;
  logic rst_n;
  logic flt_valid, flt_inhibit, step_done, step_flag, nxm_evt;
  logic sw_load, sw_force, sw_store;
  logic [1:0] flt_code;
  logic [W-1:0] sw_data, stat_o, store_o;
  logic irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  fault_status_reg uut (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_code(flt_code),
    .flt_inhibit(flt_inhibit), .step_done(step_done), .step_flag(step_flag),
    .nxm_evt(nxm_evt), .sw_load(sw_load), .sw_force(sw_force),
    .sw_store(sw_store), .sw_data(sw_data), .stat_o(stat_o),
    .store_o(store_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    flt_valid = 0; flt_code = 0; flt_inhibit = 0; step_done = 0; step_flag = 0;
    nxm_evt = 0; sw_load = 0; sw_force = 0; sw_store = 0; sw_data = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    rst_n = 1'b0;
    #(PERIOD * 3);
    @(negedge clk);
    // R12 reset state
    check("R12 stat", stat_o, 12'h040);
    check("R12 store", store_o, 12'h000);
    check("R12 irq", {11'b0, irq_o}, 12'h000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      flt_valid = TBL[i].fv;  flt_code = TBL[i].code; flt_inhibit = TBL[i].inh;
      step_done = TBL[i].sd;  step_flag = TBL[i].sf;  nxm_evt = TBL[i].nx;
      sw_load = TBL[i].ld;    sw_force = TBL[i].fc;   sw_data = TBL[i].data;
      @(negedge clk);
      idle();
      check($sformatf("vec%0d stat", i), stat_o, TBL[i].exp);
      check($sformatf("vec%0d irq R10", i), {11'b0, irq_o}, {11'b0, TBL[i].irq});
    end

    // R11: store captures value before same-cycle update
    @(negedge clk);
    sw_store = 1'b1; flt_valid = 1'b1; flt_code = 2'd0;
    @(negedge clk);
    idle();
    check("R11 store", store_o, 12'h052);
    check("R11 stat", stat_o, 12'h04A);
    // R10: request held across idle cycles
    repeat (3) @(negedge clk);
    check("R10 held", {11'b0, irq_o}, 12'h001);
    // R4: force keeps given reasons even with step clear
    sw_force = 1'b1; sw_data = 12'h010;
    @(negedge clk);
    idle();
    check("R4 force", stat_o, 12'h052);
    // R12: reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R12 rerst stat", stat_o, 12'h040);
    check("R12 rerst store", store_o, 12'h000);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule